// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus (SCL clock, open-drain SDA data). It works entirely in the system-clock domain. SCL and SDA are oversampled through synchronisers and edge detectors, so the system clock must run at least 16 times faster than SCL. The block finds START and STOP conditions on the bus and compares the first byte after a START with its own address. One bit of that address comes from a strap pin, so two copies of the block can share one bus.

After a write address, the first byte is a command code that selects one internal register. The byte after it, if sent, is written into that register. After a read address, the block returns bytes from the register that the last command code selected. The pointer never advances by itself, so a new register needs a new command byte. Three registers are writable and drive output ports: a divide select, a control register and a frequency-tuning offset. A 16-bit temperature input can be read as one or two bytes.

The block never stretches the clock. It does not answer a general call and has no 10-bit addressing. A host that wants a different register sends a write address and a command byte, and then either stops or issues a repeated START and reads.

Top module: `tw_reg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1000 10 followed by the strap value. Bit 0 of that byte is the direction: 0 for write, 1 for read. For example, the read address with the strap at 0 is 89h.
- R2: After an address that does not match, the block never pulls SDA low and changes no register until the next START.
- R3: A START (SDA falls while SCL is high) begins a new address phase at any point, including in the middle of a transfer. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R4: The SDA output enable changes only while SCL is low. Read data is sent MSB first, and a 1 bit is sent by releasing SDA.
- R5: The block always acknowledges the byte that follows a write address and stores it as the register pointer. The pointer does not change on reads or writes, so it still holds after STOP until the next command byte.
- R6: In a write, one data byte is acknowledged and stored. Code 5Dh selects the divide select register, 60h the control register (only bits 3:0 are kept; bits 7:4 read as 0) and 66h the tuning register. Any further data byte in the same transfer gets no acknowledge.
- R7: A data byte written while the pointer is 64h (temperature) or an unlisted code is acknowledged and changes no register.
- R8: A read from 5Dh, 60h or 66h returns that register as the first byte. Every later byte in the same read is FFh.
- R9: A read from 64h returns the upper temperature byte first and then the lower byte. Both bytes come from a copy of the temperature taken when the read address is accepted, so a change of the input between the two bytes does not tear the value. A NACK after the first byte is a legal way to end the read.
- R10: After the master NACKs a read byte, SDA stays released, even if the master keeps clocking, until a START or STOP.
- R11: A read from any code other than 5Dh, 60h, 64h or 66h returns FFh. Out of reset the pointer is 00h.
- R12: Out of reset all three writable registers are 00h and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap_i | input | 1 | Strap that sets the last address bit |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High to pull SDA low (open drain) |
| temp_i | input | 16 | Temperature value, upper byte sent first |
| div_sel_o | output | 8 | Divide select register |
| ctrl_o | output | 8 | Control register (bits 7:4 always 0) |
| tune_o | output | 8 | Frequency tuning register |

## Verification
The bench sends every 7-bit address with the strap at 0, and both candidate addresses with the strap at 1. A loose address compare would show up as an acknowledge on a wrong address, and a compare that ignores the strap would answer on both straps. It writes and then reads back, over repeated STARTs, a band of command codes around the known ones. This exposes a pointer that advances between bytes, a write that lands on the temperature code or an unlisted code, unmasked control bits, and a read of a trailing byte that gives anything other than FFh. The temperature input is changed between the two bytes of a read: a design that reads the live input instead of a captured copy returns torn values. After a NACK the bench keeps clocking and checks that the line stays high, which fails on a design that keeps driving data. An extra write byte must get no acknowledge, and the bench checks that the tuning register keeps the first byte.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int BYTE_W = 8;
  localparam int TEMP_W = 16;

  localparam logic [7:0] CMD_DIV  = 8'h5D;
  localparam logic [7:0] CMD_CTRL = 8'h60;
  localparam logic [7:0] CMD_TEMP = 8'h64;
  localparam logic [7:0] CMD_TUNE = 8'h66;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] CTRL_KEEP  = 8'h0F;
  localparam logic [5:0] ADDR_FIXED = 6'b100010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK, ST_HOLD
  } tw_state_e;

  // Address compare: fixed six bits, strap bit, direction ignored.
  function automatic logic addr_hit(input logic [7:0] b, input logic strap);
    return (b[7:2] == ADDR_FIXED) && (b[1] == strap);
  endfunction

  function automatic logic cmd_writable(input logic [7:0] c);
    return (c == CMD_DIV) || (c == CMD_CTRL) || (c == CMD_TUNE);
  endfunction

  // Byte index inside one read, saturating at 2.
  function automatic logic [1:0] idx_step(input logic [1:0] i);
    return (i == 2'd2) ? 2'd2 : i + 2'd1;
  endfunction

  // Read data for a pointer and byte index.
  function automatic logic [7:0] pick_rd(input logic [7:0] ptr,
                                         input logic [1:0] idx,
                                         input logic [7:0] div,
                                         input logic [7:0] ctrl,
                                         input logic [7:0] tune,
                                         input logic [TEMP_W-1:0] temp);
    logic [7:0] r;
    r = FILL_BYTE;
    case (ptr)
      CMD_DIV:  if (idx == 2'd0) r = div;
      CMD_CTRL: if (idx == 2'd0) r = ctrl;
      CMD_TUNE: if (idx == 2'd0) r = tune;
      CMD_TEMP: begin
        if (idx == 2'd0)      r = temp[TEMP_W-1:TEMP_W-8];
        else if (idx == 2'd1) r = temp[7:0];
      end
      default: r = FILL_BYTE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic [STAGES-1:0] sh;
      logic              prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh   <= '1;
          prev <= 1'b1;
        end else begin
          sh   <= {sh[STAGES-2:0], d_i[g]};
          prev <= sh[STAGES-1];
        end
      end
      assign lvl_o[g]  = sh[STAGES-1];
      assign rise_o[g] = sh[STAGES-1] & ~prev;
      assign fall_o[g] = ~sh[STAGES-1] & prev;
    end
  endgenerate

endmodule

// File: rtl/tw_regbank.sv
module tw_regbank
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_ptr,
  input  logic [7:0]        wr_data,
  input  logic              snap_en,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [7:0]        rd_ptr,
  input  logic [1:0]        rd_idx,
  output logic [7:0]        div_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        tune_o,
  output logic [7:0]        rd_byte_o
);

  logic [TEMP_W-1:0] temp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_o  <= '0;
      ctrl_o <= '0;
      tune_o <= '0;
      temp_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_ptr)
          CMD_DIV:  div_o  <= wr_data;
          CMD_CTRL: ctrl_o <= wr_data & CTRL_KEEP;
          CMD_TUNE: tune_o <= wr_data;
          default:  ;
        endcase
      end
      if (snap_en) temp_q <= temp_i;
    end
  end

  assign rd_byte_o = pick_rd(rd_ptr, rd_idx, div_o, ctrl_o, tune_o, temp_q);

  AST_WR_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cmd_writable(wr_ptr)) |=> ($stable(div_o) && $stable(ctrl_o) && $stable(tune_o))); // R7

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (ctrl_o[7:4] == 4'h0)); // R6

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [7:0]        div_sel_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        tune_o
);

  // Synchronised line levels and edges
  logic scl_lvl, sda_lvl, scl_rise, sda_rise, scl_fall, sda_fall;

  tw_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({scl_i, sda_i}),
    .lvl_o  ({scl_lvl, sda_lvl}),
    .rise_o ({scl_rise, sda_rise}),
    .fall_o ({scl_fall, sda_fall})
  );

  // Named bus events
  logic start_evt, stop_evt;
  assign start_evt = sda_fall & scl_lvl;
  assign stop_evt  = sda_rise & scl_lvl;

  tw_state_e         state, ack_next;
  logic [7:0]        shreg;
  logic [2:0]        bitcnt;
  logic              byte_full;
  logic [7:0]        ptr;
  logic [1:0]        rd_idx;
  logic [6:0]        tx;
  logic              oe_q;
  logic [7:0]        rd_byte;

  logic byte_end, addr_ok, wr_fire, snap_fire;
  assign byte_end  = scl_fall & byte_full & ~start_evt & ~stop_evt;
  assign addr_ok   = addr_hit(shreg, addr_strap_i);
  assign wr_fire   = (state == ST_WDATA) & byte_end;
  assign snap_fire = (state == ST_ADDR) & byte_end & addr_ok & shreg[0];

  tw_regbank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_fire),
    .wr_ptr    (ptr),
    .wr_data   (shreg),
    .snap_en   (snap_fire),
    .temp_i    (temp_i),
    .rd_ptr    (ptr),
    .rd_idx    (rd_idx),
    .div_o     (div_sel_o),
    .ctrl_o    (ctrl_o),
    .tune_o    (tune_o),
    .rd_byte_o (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_next  <= ST_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      byte_full <= 1'b0;
      ptr       <= '0;
      rd_idx    <= '0;
      tx        <= '0;
      oe_q      <= 1'b0;
    end else if (start_evt) begin
      state     <= ST_ADDR;
      bitcnt    <= '0;
      byte_full <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_evt) begin
      state     <= ST_IDLE;
      byte_full <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) byte_full <= 1'b1;
          end else if (byte_end) begin
            byte_full <= 1'b0;
            if (state == ST_ADDR) begin
              if (addr_ok) begin
                oe_q     <= 1'b1;
                state    <= ST_ACK;
                ack_next <= shreg[0] ? ST_RDATA : ST_CMD;
                rd_idx   <= 2'd0;
              end else begin
                state <= ST_HOLD;
              end
            end else if (state == ST_CMD) begin
              ptr      <= shreg;
              oe_q     <= 1'b1;
              state    <= ST_ACK;
              ack_next <= ST_WDATA;
            end else begin
              oe_q     <= 1'b1;
              state    <= ST_ACK;
              ack_next <= ST_HOLD;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            state  <= ack_next;
            if (ack_next == ST_RDATA) begin
              tx   <= rd_byte[6:0];
              oe_q <= ~rd_byte[7];
            end else begin
              oe_q <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) byte_full <= 1'b1;
          end else if (scl_fall) begin
            if (byte_full) begin
              byte_full <= 1'b0;
              oe_q      <= 1'b0;
              state     <= ST_RACK;
              rd_idx    <= idx_step(rd_idx);
            end else begin
              oe_q <= ~tx[6];
              tx   <= {tx[5:0], 1'b1};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_lvl) begin
            state <= ST_HOLD;
          end else if (scl_fall) begin
            bitcnt <= '0;
            state  <= ST_RDATA;
            tx     <= rd_byte[6:0];
            oe_q   <= ~rd_byte[7];
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_lvl); // R4

  AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> ((state == ST_ADDR) && !sda_oe_o)); // R3

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> ((state == ST_IDLE) && !sda_oe_o)); // R3

  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !sda_oe_o); // R2, R10

  AST_NACK_GOES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RACK) && scl_rise && sda_lvl && !start_evt && !stop_evt) |=> (state == ST_HOLD)); // R10

  AST_PTR_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CMD) |=> $stable(ptr)); // R5

endmodule

// File: tb/tw_reg_slave_tb.sv
module tw_reg_slave_tb;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [15:0] temp = 16'hEC40;
  logic sda_oe;
  logic [7:0] div_sel, ctrl, tune;
  logic sda_line;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_div = 8'h00, m_ctrl = 8'h00, m_tune = 8'h00;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  tw_reg_slave u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_strap_i (strap),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .temp_i       (temp),
    .div_sel_o    (div_sel),
    .ctrl_o       (ctrl),
    .tune_o       (tune)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    if (scl_m == 1'b0) begin
      sda_m = 1'b1; wq(1);
      scl_m = 1'b1; wq(1);
    end
    sda_m = 1'b0; wq(2);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    acked = ~sda_line; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic rbyte(input logic mnack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(1);
      scl_m = 1'b1; wq(1);
      b[i] = sda_line; wq(1);
      scl_m = 1'b0; wq(1);
    end
    sda_m = mnack; wq(1);
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq(1);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {6'b100010, strap, rw};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] code, input int idx);
    if (code == 8'h5D) return (idx == 0) ? m_div : 8'hFF;
    if (code == 8'h60) return (idx == 0) ? m_ctrl : 8'hFF;
    if (code == 8'h66) return (idx == 0) ? m_tune : 8'hFF;
    if (code == 8'h64) return (idx == 0) ? temp[15:8] : ((idx == 1) ? temp[7:0] : 8'hFF);
    return 8'hFF;
  endfunction

  initial begin
    repeat (200000 - 100) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq(2);

    // R12: reset state
    chk("R12 div", {8'h0, div_sel}, 16'h0);
    chk("R12 ctrl", {8'h0, ctrl}, 16'h0);
    chk("R12 tune", {8'h0, tune}, 16'h0);
    chk("R12 sda released", {15'h0, sda_oe}, 16'h0);

    // R11: pointer 00h after reset reads FFh; R1 read address acked
    bus_start; wbyte(dev(1'b1), ak);
    chk("R1 read address ack", {15'h0, ak}, 16'h1);
    rbyte(1'b1, rd);
    chk("R11 reset pointer read", {8'h0, rd}, 16'h00FF);
    bus_stop;

    // R1/R2: every 7-bit address, strap 0
    for (int a = 0; a < 128; a++) begin
      bus_start; wbyte({a[6:0], 1'b0}, ak);
      chk("R1 R2 address sweep", {15'h0, ak},
          {15'h0, (a[6:0] == {6'b100010, 1'b0})});
      bus_stop;
    end

    // R1: strap 1 moves the address
    strap = 1'b1; wq(2);
    bus_start; wbyte({7'h44, 1'b0}, ak); bus_stop;
    chk("R1 strap1 rejects 44h", {15'h0, ak}, 16'h0);
    bus_start; wbyte({7'h45, 1'b0}, ak); bus_stop;
    chk("R1 strap1 accepts 45h", {15'h0, ak}, 16'h1);

    // R2: mismatch then payload has no effect
    bus_start; wbyte({7'h44, 1'b0}, ak);
    wbyte(8'h5D, ak);
    chk("R2 no ack after mismatch", {15'h0, ak}, 16'h0);
    wbyte(8'h33, ak);
    chk("R2 no ack on data", {15'h0, ak}, 16'h0);
    bus_stop;
    chk("R2 div untouched", {8'h0, div_sel}, 16'h0);

    // R5/R6/R7: write sweep over codes 5Ch..67h
    for (int c = 8'h5C; c <= 8'h67; c++) begin
      logic [7:0] code, dat;
      code = c[7:0];
      dat  = code ^ 8'hA5;
      bus_start; wbyte(dev(1'b0), ak);
      wbyte(code, ak);
      chk("R5 command ack", {15'h0, ak}, 16'h1);
      wbyte(dat, ak);
      chk("R6 R7 data ack", {15'h0, ak}, 16'h1);
      bus_stop;
      if (code == 8'h5D) m_div = dat;
      if (code == 8'h60) m_ctrl = dat & 8'h0F;
      if (code == 8'h66) m_tune = dat;
      chk("R6 R7 div", {8'h0, div_sel}, {8'h0, m_div});
      chk("R6 R7 ctrl", {8'h0, ctrl}, {8'h0, m_ctrl});
      chk("R6 R7 tune", {8'h0, tune}, {8'h0, m_tune});
    end

    // R8/R9/R11/R3/R4: read sweep with repeated START, three bytes each
    for (int c = 8'h5C; c <= 8'h67; c++) begin
      logic [7:0] code;
      code = c[7:0];
      bus_start; wbyte(dev(1'b0), ak); wbyte(code, ak);
      bus_start; wbyte(dev(1'b1), ak);
      chk("R3 repeated start read ack", {15'h0, ak}, 16'h1);
      for (int k = 0; k < 3; k++) begin
        rbyte((k == 2), rd);
        chk("R8 R9 R11 R4 read byte", {8'h0, rd}, {8'h0, exp_rd(code, k)});
      end
      bus_stop;
    end

    // R9: temperature copy survives input change; R5 pointer persists
    temp = 16'h1940;
    bus_start; wbyte(dev(1'b0), ak); wbyte(8'h64, ak);
    bus_start; wbyte(dev(1'b1), ak);
    rbyte(1'b0, rd);
    chk("R9 temp upper", {8'h0, rd}, 16'h0019);
    temp = 16'h7FC0;
    rbyte(1'b1, rd);
    chk("R9 temp lower from copy", {8'h0, rd}, 16'h0040);
    bus_stop;

    bus_start; wbyte(dev(1'b1), ak);
    rbyte(1'b1, rd);
    chk("R9 R5 single byte temp read", {8'h0, rd}, 16'h007F);
    // R10: after NACK the line stays released
    rbyte(1'b1, rd);
    chk("R10 released after nack", {8'h0, rd}, 16'h00FF);
    bus_stop;

    // R6: extra data byte is not acknowledged
    bus_start; wbyte(dev(1'b0), ak); wbyte(8'h66, ak);
    wbyte(8'h5A, ak);
    chk("R6 first data ack", {15'h0, ak}, 16'h1);
    wbyte(8'h11, ak);
    chk("R6 extra byte nack", {15'h0, ak}, 16'h0);
    bus_stop;
    chk("R6 tune keeps first byte", {8'h0, tune}, 16'h005A);

    // R6: control keeps only bits 3:0
    bus_start; wbyte(dev(1'b0), ak); wbyte(8'h60, ak); wbyte(8'hFF, ak); bus_stop;
    chk("R6 ctrl masked", {8'h0, ctrl}, 16'h000F);

    // R3: START in the middle of a data byte aborts it
    bus_start; wbyte(dev(1'b0), ak); wbyte(8'h5D, ak);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    end
    bus_start; wbyte(dev(1'b1), ak);
    rbyte(1'b1, rd);
    bus_stop;
    chk("R3 aborted write leaves div", {8'h0, rd}, {8'h0, m_div});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule